// File: doc/BRIEF.md
# Exception Control Register File

This block holds the three control registers a small 32-bit in-order core needs to take and leave exceptions. These are the saved exception PC, the cause word and the status word. On every cycle the core reports what its retiring instruction did. The choices are nothing special, a system call, a reserved or unsupported instruction, an external interrupt taken at commit, or a return from an exception handler. The block updates its registers at the next clock edge. In the same cycle it produces the next fetch address and a redirect flag, so that fetch can jump to the fixed handler address or back to the saved PC.

The status word keeps a three-deep stack of (user mode, interrupt enable) pairs. Taking an exception pushes a kernel-mode, interrupts-off pair onto the stack. A return pops the stack, so nested state comes back without help from handler code. Decode uses the current mode and enable bits, which are presented as outputs. Handler code can read any register and write any register through a register-number select.

Top module: `exc_ctrl_regs`

## Requirements
- R1: While reset is high and after it is released, every status pair is (kernel, disabled), the interrupt mask is zero, and cause and saved PC read zero. kernel_mode is 1 and irq_enable is 0.
- R2: The taken events are system call (event code 1), reserved instruction (2), external interrupt (3) and a user-mode return. On a taken event, at the next edge the middle pair moves to the deepest slot, the current pair moves to the middle slot, and the current pair becomes (kernel, disabled).
- R3: A return (event code 4) in kernel mode pops the stack at the next edge. The middle pair becomes current, and the deepest pair is copied into the middle slot and also keeps its own value.
- R4: After a taken event, the 5-bit code in cause bits 6:2 is 8 for a system call, 10 for a reserved instruction or a user-mode return, and 0 for an external interrupt.
- R5: After a taken event, the saved PC holds the ev_pc value of the cycle in which the event was reported.
- R6: In the cycle of a taken event, next_pc equals the handler address parameter and redirect is 1.
- R7: In the cycle of a kernel-mode return, next_pc equals the saved PC held at that moment and redirect is 1.
- R8: With event code 0, redirect is 0. next_pc is br_target when br_taken is 1, and ev_pc + 4 when it is 0.
- R9: A return reported while the current pair is in user mode is not popped. It is handled exactly like a reserved instruction.
- R10: Register select 12 is status, 13 is cause and 14 is the saved PC. In status, bits 15:8 are the mask, and bits 1:0, 3:2 and 5:4 are the current, middle and deepest pairs, each with the enable bit in the lower position and the user bit in the upper position. In cause, only bits 6:2 are kept. Bits that are not kept, and every other select, read as zero. A write takes effect at the next edge, and a read is combinational.
- R11: When a software write and a hardware update hit the same register in the same cycle, the hardware update wins. A software write to a register that the hardware update leaves untouched still takes effect.
- R12: kernel_mode is the inverse of the current user bit, and irq_enable is the current enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_kind | input | 3 | Retire event: 0 none, 1 system call, 2 reserved instruction, 3 external interrupt, 4 return; 5 to 7 treated as none |
| ev_pc | input | 32 | PC of the retiring instruction |
| br_taken | input | 1 | The retiring instruction is a taken branch |
| br_target | input | 32 | Branch target address |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_wr_sel | input | 5 | Register number for the write |
| sw_wr_data | input | 32 | Write data |
| sw_rd_sel | input | 5 | Register number for the read |
| sw_rd_data | output | 32 | Read data, combinational |
| next_pc | output | 32 | Next fetch address |
| redirect | output | 1 | next_pc is a handler or return address |
| kernel_mode | output | 1 | Current pair is kernel mode |
| irq_enable | output | 1 | Current pair has interrupts enabled |

## Verification
next_pc, redirect and sw_rd_data are combinational, so they are due in the cycle an event or select is applied. The status stack, cause and saved PC change at the first rising edge after the event, so their effects become visible one cycle later, and kernel_mode and irq_enable follow them one cycle later as well. The bench drives each stimulus on the falling edge and samples the combinational results shortly afterwards, before the next rising edge. It then samples register contents one time unit after that rising edge. Each stack test starts from a known pattern that is written through the software port, so that every pair movement shows up as a different bit pattern.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;

    localparam int XLEN     = 32;
    localparam int SEL_W    = 5;
    localparam int CODE_W   = 5;
    localparam int CODE_LSB = 2;
    localparam int MASK_LSB = 8;

    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_SYSCALL = 3'd1,
        EV_RSVD    = 3'd2,
        EV_EXTINT  = 3'd3,
        EV_ERET    = 3'd4
    } retire_ev_e;

    typedef struct packed {
        logic user;
        logic ie;
    } mode_pair_t;

    localparam mode_pair_t PAIR_KERNEL_OFF = '{user: 1'b0, ie: 1'b0};

    localparam logic [CODE_W-1:0] CODE_EXTINT  = 5'd0;
    localparam logic [CODE_W-1:0] CODE_SYSCALL = 5'd8;
    localparam logic [CODE_W-1:0] CODE_RSVD    = 5'd10;

    localparam logic [SEL_W-1:0] SEL_STATUS = 5'd12;
    localparam logic [SEL_W-1:0] SEL_CAUSE  = 5'd13;
    localparam logic [SEL_W-1:0] SEL_EPC    = 5'd14;

    function automatic retire_ev_e to_event(input logic [2:0] raw);
        case (raw)
            3'd1:    return EV_SYSCALL;
            3'd2:    return EV_RSVD;
            3'd3:    return EV_EXTINT;
            3'd4:    return EV_ERET;
            default: return EV_NONE;
        endcase
    endfunction

endpackage

// File: rtl/exc_event_decode.sv
module exc_event_decode
    import exc_ctrl_pkg::*;
(
    input  logic [2:0]        ev_raw,
    input  logic              cur_user,
    output logic              take_exc,
    output logic              do_pop,
    output logic [CODE_W-1:0] exc_code
);

    retire_ev_e ev;

    always_comb begin
        ev       = to_event(ev_raw);
        take_exc = 1'b0;
        do_pop   = 1'b0;
        exc_code = CODE_EXTINT;
        case (ev)
            EV_SYSCALL: begin
                take_exc = 1'b1;
                exc_code = CODE_SYSCALL;
            end
            EV_RSVD: begin
                take_exc = 1'b1;
                exc_code = CODE_RSVD;
            end
            EV_EXTINT: begin
                take_exc = 1'b1;
                exc_code = CODE_EXTINT;
            end
            EV_ERET: begin
                // a return is privileged: from user mode it faults
                if (cur_user) begin
                    take_exc = 1'b1;
                    exc_code = CODE_RSVD;
                end else begin
                    do_pop = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/exc_status_stack.sv
module exc_status_stack
    import exc_ctrl_pkg::*;
#(
    parameter int DEPTH  = 3,
    parameter int MASK_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    input  logic            sw_we,
    input  logic [XLEN-1:0] sw_data,
    output logic [XLEN-1:0] status_word,
    output mode_pair_t      cur_pair
);

    localparam int PAIR_BITS = 2 * DEPTH;

    mode_pair_t              stack_q [DEPTH];
    logic       [MASK_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stack_q[i] <= PAIR_KERNEL_OFF;
            mask_q <= '0;
        end else if (push) begin
            stack_q[0] <= PAIR_KERNEL_OFF;
            for (int i = 1; i < DEPTH; i++) stack_q[i] <= stack_q[i-1];
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) stack_q[i] <= stack_q[i+1];
            stack_q[DEPTH-1] <= stack_q[DEPTH-1];
        end else if (sw_we) begin
            for (int i = 0; i < DEPTH; i++) stack_q[i] <= mode_pair_t'(sw_data[2*i +: 2]);
            mask_q <= sw_data[MASK_LSB +: MASK_W];
        end
    end

    logic [PAIR_BITS-1:0] pairs_flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_pack
        assign pairs_flat[2*g +: 2] = stack_q[g];
    end

    always_comb begin
        status_word                      = '0;
        status_word[PAIR_BITS-1:0]       = pairs_flat;
        status_word[MASK_LSB +: MASK_W]  = mask_q;
    end

    assign cur_pair = stack_q[0];

endmodule

// File: rtl/exc_next_pc.sv
module exc_next_pc
    import exc_ctrl_pkg::*;
#(
    parameter logic [XLEN-1:0] HANDLER_PC = 32'h8000_0080
) (
    input  logic            take_exc,
    input  logic            do_pop,
    input  logic [XLEN-1:0] epc,
    input  logic [XLEN-1:0] ev_pc,
    input  logic            br_taken,
    input  logic [XLEN-1:0] br_target,
    output logic [XLEN-1:0] next_pc,
    output logic            redirect
);

    always_comb begin
        redirect = take_exc | do_pop;
        if (take_exc)      next_pc = HANDLER_PC;
        else if (do_pop)   next_pc = epc;
        else if (br_taken) next_pc = br_target;
        else               next_pc = ev_pc + XLEN'(4);
    end

endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
    import exc_ctrl_pkg::*;
#(
    parameter logic [31:0] HANDLER_PC = 32'h8000_0080,
    parameter int          DEPTH      = 3,
    parameter int          MASK_W     = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  ev_kind,
    input  logic [31:0] ev_pc,
    input  logic        br_taken,
    input  logic [31:0] br_target,
    input  logic        sw_wr_en,
    input  logic [4:0]  sw_wr_sel,
    input  logic [31:0] sw_wr_data,
    input  logic [4:0]  sw_rd_sel,
    output logic [31:0] sw_rd_data,
    output logic [31:0] next_pc,
    output logic        redirect,
    output logic        kernel_mode,
    output logic        irq_enable
);

    logic              take_exc;
    logic              do_pop;
    logic [CODE_W-1:0] exc_code;
    logic [CODE_W-1:0] cause_q;
    logic [XLEN-1:0]   epc_q;
    logic [XLEN-1:0]   status_word;
    logic [XLEN-1:0]   cause_word;
    mode_pair_t        cur_pair;

    wire wr_status = sw_wr_en && (sw_wr_sel == SEL_STATUS);
    wire wr_cause  = sw_wr_en && (sw_wr_sel == SEL_CAUSE);
    wire wr_epc    = sw_wr_en && (sw_wr_sel == SEL_EPC);

    exc_event_decode u_decode (
        .ev_raw   (ev_kind),
        .cur_user (cur_pair.user),
        .take_exc (take_exc),
        .do_pop   (do_pop),
        .exc_code (exc_code)
    );

    exc_status_stack #(
        .DEPTH  (DEPTH),
        .MASK_W (MASK_W)
    ) u_status (
        .clk         (clk),
        .rst         (rst),
        .push        (take_exc),
        .pop         (do_pop),
        .sw_we       (wr_status),
        .sw_data     (sw_wr_data),
        .status_word (status_word),
        .cur_pair    (cur_pair)
    );

    exc_next_pc #(
        .HANDLER_PC (HANDLER_PC)
    ) u_npc (
        .take_exc  (take_exc),
        .do_pop    (do_pop),
        .epc       (epc_q),
        .ev_pc     (ev_pc),
        .br_taken  (br_taken),
        .br_target (br_target),
        .next_pc   (next_pc),
        .redirect  (redirect)
    );

    // hardware update takes precedence over a software write
    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            epc_q   <= '0;
        end else if (take_exc) begin
            cause_q <= exc_code;
            epc_q   <= ev_pc;
        end else begin
            if (wr_cause) cause_q <= sw_wr_data[CODE_LSB +: CODE_W];
            if (wr_epc)   epc_q   <= sw_wr_data;
        end
    end

    always_comb begin
        cause_word                      = '0;
        cause_word[CODE_LSB +: CODE_W]  = cause_q;
    end

    always_comb begin
        case (sw_rd_sel)
            SEL_STATUS: sw_rd_data = status_word;
            SEL_CAUSE:  sw_rd_data = cause_word;
            SEL_EPC:    sw_rd_data = epc_q;
            default:    sw_rd_data = '0;
        endcase
    end

    assign kernel_mode = ~cur_pair.user;
    assign irq_enable  = cur_pair.ie;

endmodule

// File: rtl/exc_ctrl_regs_chk.sv
module exc_ctrl_regs_chk #(
    parameter logic [31:0] HANDLER_PC = 32'h8000_0080
) (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  ev_kind,
    input logic [31:0] ev_pc,
    input logic [31:0] next_pc,
    input logic        redirect,
    input logic        kernel_mode,
    input logic        irq_enable,
    input logic [31:0] status_w,
    input logic [31:0] cause_w,
    input logic [31:0] epc_w
);

    wire is_eret = (ev_kind == 3'd4);
    wire exc_now = (ev_kind == 3'd1) || (ev_kind == 3'd2) || (ev_kind == 3'd3)
                   || (is_eret && !kernel_mode);
    wire pop_now = is_eret && kernel_mode;

    // R2
    push_state_chk: assert property (@(posedge clk) disable iff (rst)
        exc_now |=> (kernel_mode && !irq_enable));

    // R3
    pop_shift_chk: assert property (@(posedge clk) disable iff (rst)
        pop_now |=> (status_w[1:0] == $past(status_w[3:2]))
                 && (status_w[3:2] == $past(status_w[5:4]))
                 && (status_w[5:4] == $past(status_w[5:4])));

    // R4
    syscall_code_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_kind == 3'd1) |=> (cause_w[6:2] == 5'd8));

    // R5
    epc_load_chk: assert property (@(posedge clk) disable iff (rst)
        exc_now |=> (epc_w == $past(ev_pc)));

    // R6
    handler_target_chk: assert property (@(posedge clk) disable iff (rst)
        exc_now |-> (redirect && next_pc == HANDLER_PC));

    // R7
    return_target_chk: assert property (@(posedge clk) disable iff (rst)
        pop_now |-> (redirect && next_pc == epc_w));

    // R8
    quiet_no_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_kind == 3'd0) |-> !redirect);

endmodule

bind exc_ctrl_regs exc_ctrl_regs_chk #(.HANDLER_PC(HANDLER_PC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_kind     (ev_kind),
    .ev_pc       (ev_pc),
    .next_pc     (next_pc),
    .redirect    (redirect),
    .kernel_mode (kernel_mode),
    .irq_enable  (irq_enable),
    .status_w    (status_word),
    .cause_w     (cause_word),
    .epc_w       (epc_q)
);

// File: tb/exc_ctrl_regs_bench.sv
module exc_ctrl_regs_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] HANDLER    = 32'h8000_0080;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  ev_kind = '0;
    logic [31:0] ev_pc = '0;
    logic        br_taken = 1'b0;
    logic [31:0] br_target = '0;
    logic        sw_wr_en = 1'b0;
    logic [4:0]  sw_wr_sel = '0;
    logic [31:0] sw_wr_data = '0;
    logic [4:0]  sw_rd_sel = '0;
    logic [31:0] sw_rd_data;
    logic [31:0] next_pc;
    logic        redirect;
    logic        kernel_mode;
    logic        irq_enable;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_ctrl_regs #(.HANDLER_PC(HANDLER)) u_exc_ctrl_regs (
        .clk         (clk),
        .rst         (rst),
        .ev_kind     (ev_kind),
        .ev_pc       (ev_pc),
        .br_taken    (br_taken),
        .br_target   (br_target),
        .sw_wr_en    (sw_wr_en),
        .sw_wr_sel   (sw_wr_sel),
        .sw_wr_data  (sw_wr_data),
        .sw_rd_sel   (sw_rd_sel),
        .sw_rd_data  (sw_rd_data),
        .next_pc     (next_pc),
        .redirect    (redirect),
        .kernel_mode (kernel_mode),
        .irq_enable  (irq_enable)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic [4:0] sel, output logic [31:0] val);
        sw_rd_sel = sel;
        #1;
        val = sw_rd_data;
    endtask

    // apply one cycle of stimulus at the falling edge; comb outputs are valid
    // after #1, registered effects after the following rising edge
    task automatic apply(input logic [2:0] kind, input logic [31:0] pc,
                         input logic tk, input logic [31:0] tgt,
                         input logic we, input logic [4:0] wsel, input logic [31:0] wd);
        @(negedge clk);
        ev_kind = kind; ev_pc = pc; br_taken = tk; br_target = tgt;
        sw_wr_en = we; sw_wr_sel = wsel; sw_wr_data = wd;
        #1;
    endtask

    task automatic finish_cycle();
        @(posedge clk);
        #1;
        ev_kind = '0; br_taken = 1'b0; sw_wr_en = 1'b0;
    endtask

    task automatic sw_write(input logic [4:0] sel, input logic [31:0] d);
        apply(3'd0, 32'h0, 1'b0, 32'h0, 1'b1, sel, d);
        finish_cycle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        read_reg(5'd12, v); check("R1 status", v, 32'h0);
        read_reg(5'd13, v); check("R1 cause", v, 32'h0);
        read_reg(5'd14, v); check("R1 epc", v, 32'h0);
        check("R1 kernel_mode", {31'b0, kernel_mode}, 32'd1);
        check("R1 irq_enable", {31'b0, irq_enable}, 32'd0);
    endtask

    task automatic t_sequential();
        apply(3'd0, 32'h100, 1'b0, 32'h2000, 1'b0, 5'd0, 32'h0);
        check("R8 pc+4", next_pc, 32'h104);
        check("R8 no redirect", {31'b0, redirect}, 32'd0);
        finish_cycle();
        apply(3'd0, 32'h100, 1'b1, 32'h2000, 1'b0, 5'd0, 32'h0);
        check("R8 taken branch", next_pc, 32'h2000);
        finish_cycle();
        apply(3'd6, 32'h200, 1'b0, 32'h0, 1'b0, 5'd0, 32'h0);
        check("R8 unused code as none", {31'b0, redirect}, 32'd0);
        finish_cycle();
    endtask

    task automatic t_sw_access();
        logic [31:0] v;
        sw_write(5'd14, 32'h1234_5678);
        read_reg(5'd14, v); check("R10 epc rw", v, 32'h1234_5678);
        sw_write(5'd13, 32'hFFFF_FFFF);
        read_reg(5'd13, v); check("R10 cause field only", v, 32'h0000_007C);
        read_reg(5'd5, v); check("R10 unmapped reads zero", v, 32'h0);
        sw_write(5'd12, 32'hFFFF_FFFF);
        read_reg(5'd12, v); check("R10 status field only", v, 32'h0000_FF3F);
    endtask

    task automatic t_syscall_and_return();
        logic [31:0] v;
        sw_write(5'd12, 32'h0000_A527);
        check("R12 user mode out", {31'b0, kernel_mode}, 32'd0);
        check("R12 enable out", {31'b0, irq_enable}, 32'd1);
        apply(3'd1, 32'h400, 1'b0, 32'h0, 1'b0, 5'd0, 32'h0);
        check("R6 handler pc", next_pc, HANDLER);
        check("R6 redirect", {31'b0, redirect}, 32'd1);
        finish_cycle();
        read_reg(5'd12, v); check("R2 push", v, 32'h0000_A51C);
        read_reg(5'd13, v); check("R4 syscall code", v, 32'h0000_0020);
        read_reg(5'd14, v); check("R5 epc", v, 32'h400);
        check("R2 kernel after push", {31'b0, kernel_mode}, 32'd1);
        apply(3'd4, 32'h8000_0090, 1'b0, 32'h0, 1'b0, 5'd0, 32'h0);
        check("R7 return target", next_pc, 32'h400);
        check("R7 redirect", {31'b0, redirect}, 32'd1);
        finish_cycle();
        read_reg(5'd12, v); check("R3 pop keeps deepest", v, 32'h0000_A517);
        check("R12 user restored", {31'b0, kernel_mode}, 32'd0);
    endtask

    task automatic t_user_return();
        logic [31:0] v;
        // current pair is user mode here (status A517)
        apply(3'd4, 32'h500, 1'b0, 32'h0, 1'b0, 5'd0, 32'h0);
        check("R9 handler on user return", next_pc, HANDLER);
        finish_cycle();
        read_reg(5'd12, v); check("R9 push not pop", v, 32'h0000_A51C);
        read_reg(5'd13, v); check("R9 reserved code", v, 32'h0000_0028);
        read_reg(5'd14, v); check("R9 epc", v, 32'h500);
    endtask

    task automatic t_rsvd_and_extint();
        logic [31:0] v;
        apply(3'd2, 32'h600, 1'b0, 32'h0, 1'b0, 5'd0, 32'h0);
        finish_cycle();
        read_reg(5'd13, v); check("R4 reserved code", v, 32'h0000_0028);
        read_reg(5'd12, v); check("R2 second push", v, 32'h0000_A530);
        apply(3'd3, 32'h700, 1'b0, 32'h0, 1'b0, 5'd0, 32'h0);
        check("R6 ext handler", next_pc, HANDLER);
        finish_cycle();
        read_reg(5'd13, v); check("R4 external code", v, 32'h0);
        read_reg(5'd14, v); check("R5 ext epc", v, 32'h700);
    endtask

    task automatic t_conflict();
        logic [31:0] v;
        apply(3'd1, 32'h800, 1'b0, 32'h0, 1'b1, 5'd14, 32'hDEAD_BEEF);
        finish_cycle();
        read_reg(5'd14, v); check("R11 hw epc wins", v, 32'h800);
        sw_write(5'd12, 32'h0000_0004);
        apply(3'd4, 32'h900, 1'b0, 32'h0, 1'b1, 5'd12, 32'h0000_0003);
        finish_cycle();
        read_reg(5'd12, v); check("R11 pop beats status write", v, 32'h0000_0001);
        apply(3'd4, 32'h900, 1'b0, 32'h0, 1'b1, 5'd14, 32'h0000_0ABC);
        finish_cycle();
        read_reg(5'd14, v); check("R11 untouched reg written", v, 32'h0000_0ABC);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        t_reset();
        t_sequential();
        t_sw_access();
        t_syscall_and_return();
        t_user_return();
        t_rsvd_and_extint();
        t_conflict();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule